// File: doc/BRIEF.md
# Program Counter Sequencer with Branch and Jump Redirection

This block owns the program counter of a simple 32-bit load/store processor core. Every clock cycle it looks at the instruction word fetched from the current PC, together with the two source register values already read for that instruction. From these it decides where execution continues. The choices are the next sequential word, a PC-relative branch target, a pseudo-direct jump target, or an address taken from a register.

Control transfers have no delay slot. A redirect decided for the instruction seen in one cycle appears on the PC output in the next cycle. All outputs are registered and change together at that edge:

- a one-cycle redirect indication;
- for the call-style jump, a request to write the return address into the link register;
- for the register jump, a flag raised when the loaded address is not word aligned.

Instruction fetch, the register file and hazard handling belong to neighbouring blocks.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the PC loads 0x00400000, and `taken_o`, `link_we_o` and `misalign_o` go low; `link_idx_o` and `link_data_o` go to zero.
- R2: An instruction that is not a branch or jump advances the PC by 4 at the next edge and leaves `taken_o` low. Examples are opcode 0x00 with any funct other than 0x08, or opcode 0x23.
- R3: Opcode 0x04 (branch-if-equal) redirects when `rs_val_i == rt_val_i`. The target is PC+4 plus the sign-extended 16-bit field in bits 15:0 multiplied by 4. When the values differ, the PC advances by 4.
- R4: Opcode 0x05 (branch-if-not-equal) redirects to the same kind of target when the two values differ, and advances by 4 when they are equal.
- R5: The branch offset is signed. Field values 0x8000 to 0xFFFF move the PC backwards, with the address arithmetic wrapping modulo 2^32.
- R6: Opcode 0x02 (jump) loads bits 31:28 of PC+4, followed by bits 25:0 of the instruction, followed by two zero bits. The upper bits come from PC+4, not from the PC.
- R7: Opcode 0x03 (jump-and-link) jumps like R6. In the cycle the new PC appears, it also drives `link_we_o`=1, `link_idx_o`=31 and `link_data_o`=(old PC)+4. In every other cycle `link_we_o`=0 and `link_idx_o`=0.
- R8: Opcode 0x00 with funct (bits 5:0) equal to 0x08 (register jump) loads the PC with `rs_val_i`.
- R9: A register jump whose target has nonzero bits 1:0 still loads that value. It raises `misalign_o` for exactly the cycle in which that PC is shown.
- R10: `taken_o` is high for exactly the cycle in which a redirected PC is shown. It is low after every sequential step and after every branch that is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word fetched from `pc_o` |
| rs_val_i | input | XLEN | Value of the first source register of `instr_i` |
| rt_val_i | input | XLEN | Value of the second source register of `instr_i` |
| pc_o | output | XLEN | Current program counter |
| taken_o | output | 1 | The current PC came from a branch or jump |
| link_we_o | output | 1 | Link register write request |
| link_idx_o | output | RIDX_W | Register index for the link write |
| link_data_o | output | XLEN | Return address for the link write |
| misalign_o | output | 1 | The current PC came from a register jump with nonzero low bits |

## Verification
Several properties are checked by assertions on every cycle:

- the PC steps by exactly 4 whenever no redirect is flagged;
- an equal pair under opcode 0x04, or an unequal pair under opcode 0x05, always produces a redirect;
- a register jump always lands on the source value;
- any link request carries index 31 and the previous PC plus 4;
- a misaligned flag always coincides with a redirect to an address that is not word aligned.

The exact branch target for each offset needs the bench's arithmetic sweeps over positive, negative and extreme offsets in both compare outcomes. So do the jump-target splice near a 256 MB boundary, where PC and PC+4 differ in their top bits, and the one-cycle width of `taken_o` and `misalign_o` across back-to-back redirects.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [2:0] {
    FK_SEQ,
    FK_BEQ,
    FK_BNE,
    FK_JMP,
    FK_JAL,
    FK_JREG
  } flow_kind_e;

  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'h00;
  localparam logic [OPC_W-1:0] OPC_JMP     = 6'h02;
  localparam logic [OPC_W-1:0] OPC_JAL     = 6'h03;
  localparam logic [OPC_W-1:0] OPC_BEQ     = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BNE     = 6'h05;
  localparam logic [FN_W-1:0]  FN_JREG     = 6'h08;

endpackage

// File: rtl/pcseq_decode.sv
module pcseq_decode
  import pcseq_pkg::*;
#(
  parameter int IW    = 32,
  parameter int OFF_W = 16,
  parameter int JF_W  = 26
) (
  input  logic [IW-1:0]    instr,
  output flow_kind_e       kind,
  output logic [OFF_W-1:0] offset,
  output logic [JF_W-1:0]  jfield
);

  localparam int OPC_LSB = IW - OPC_W;

  logic [OPC_W-1:0] opcode;
  logic [FN_W-1:0]  funct;

  assign opcode = instr[IW-1:OPC_LSB];
  assign funct  = instr[FN_W-1:0];
  assign offset = instr[OFF_W-1:0];
  assign jfield = instr[JF_W-1:0];

  always_comb begin
    kind = FK_SEQ;
    unique case (opcode)
      OPC_BEQ:     kind = FK_BEQ;
      OPC_BNE:     kind = FK_BNE;
      OPC_JMP:     kind = FK_JMP;
      OPC_JAL:     kind = FK_JAL;
      OPC_SPECIAL: kind = (funct == FN_JREG) ? FK_JREG : FK_SEQ;
      default:     kind = FK_SEQ;
    endcase
  end

endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
  import pcseq_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int JF_W  = 26
) (
  input  logic [XLEN-1:0]  pc,
  input  flow_kind_e       kind,
  input  logic [OFF_W-1:0] offset,
  input  logic [JF_W-1:0]  jfield,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  output logic [XLEN-1:0]  pc_inc,
  output logic [XLEN-1:0]  next_pc,
  output logic             redirect,
  output logic             link_req,
  output logic             bad_align
);

  localparam int             STEP  = XLEN / 8 / 4 * 4;
  localparam int             ALN_W = 2;
  localparam int             SEG_W = XLEN - JF_W - ALN_W;
  localparam int             EXT_W = XLEN - OFF_W - ALN_W;
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  logic [XLEN-1:0] br_disp;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] jp_tgt;
  logic            same;

  assign pc_inc  = pc + STEP_V;
  assign br_disp = {{EXT_W{offset[OFF_W-1]}}, offset, {ALN_W{1'b0}}};
  assign br_tgt  = pc_inc + br_disp;
  assign jp_tgt  = {pc_inc[XLEN-1 -: SEG_W], jfield, {ALN_W{1'b0}}};
  assign same    = (rs_val == rt_val);

  always_comb begin
    next_pc   = pc_inc;
    redirect  = 1'b0;
    link_req  = 1'b0;
    bad_align = 1'b0;
    unique case (kind)
      FK_BEQ: begin
        if (same) begin
          next_pc  = br_tgt;
          redirect = 1'b1;
        end
      end
      FK_BNE: begin
        if (!same) begin
          next_pc  = br_tgt;
          redirect = 1'b1;
        end
      end
      FK_JMP: begin
        next_pc  = jp_tgt;
        redirect = 1'b1;
      end
      FK_JAL: begin
        next_pc  = jp_tgt;
        redirect = 1'b1;
        link_req = 1'b1;
      end
      FK_JREG: begin
        next_pc   = rs_val;
        redirect  = 1'b1;
        bad_align = |rs_val[ALN_W-1:0];
      end
      default: begin
        next_pc = pc_inc;
      end
    endcase
  end

endmodule

// File: rtl/pcseq_state.sv
module pcseq_state #(
  parameter int              XLEN     = 32,
  parameter int              RIDX_W   = 5,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0040_0000,
  parameter int              LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [XLEN-1:0]   next_pc,
  input  logic [XLEN-1:0]   ret_addr,
  input  logic              redirect,
  input  logic              link_req,
  input  logic              bad_align,
  output logic [XLEN-1:0]   pc_q,
  output logic              taken_q,
  output logic              link_we_q,
  output logic [RIDX_W-1:0] link_idx_q,
  output logic [XLEN-1:0]   link_data_q,
  output logic              misalign_q
);

  localparam logic [RIDX_W-1:0] LINK_IDX = RIDX_W'(LINK_REG);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q        <= RESET_PC;
      taken_q     <= 1'b0;
      link_we_q   <= 1'b0;
      link_idx_q  <= '0;
      link_data_q <= '0;
      misalign_q  <= 1'b0;
    end else begin
      pc_q        <= next_pc;
      taken_q     <= redirect;
      link_we_q   <= link_req;
      link_idx_q  <= link_req ? LINK_IDX : '0;
      link_data_q <= link_req ? ret_addr : '0;
      misalign_q  <= bad_align;
    end
  end

  assert_link_pairs_R7: assert property (@(posedge clk) disable iff (rst)
    link_we_q |-> (taken_q && link_idx_q == LINK_IDX));

  assert_misalign_tgt_R9: assert property (@(posedge clk) disable iff (rst)
    misalign_q |-> (taken_q && pc_q[1:0] != 2'b00));

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              RIDX_W   = 5,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0040_0000,
  parameter int              LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       instr_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  output logic [XLEN-1:0]   pc_o,
  output logic              taken_o,
  output logic              link_we_o,
  output logic [RIDX_W-1:0] link_idx_o,
  output logic [XLEN-1:0]   link_data_o,
  output logic              misalign_o
);

  localparam int              IW     = 32;
  localparam int              OFF_W  = 16;
  localparam int              JF_W   = 26;
  localparam logic [XLEN-1:0] STEP_V = XLEN'(4);

  flow_kind_e       kind;
  logic [OFF_W-1:0] offset;
  logic [JF_W-1:0]  jfield;
  logic [XLEN-1:0]  pc_inc;
  logic [XLEN-1:0]  next_pc;
  logic             redirect;
  logic             link_req;
  logic             bad_align;

  pcseq_decode #(.IW(IW), .OFF_W(OFF_W), .JF_W(JF_W)) u_dec (
    .instr  (instr_i),
    .kind   (kind),
    .offset (offset),
    .jfield (jfield)
  );

  pcseq_target #(.XLEN(XLEN), .OFF_W(OFF_W), .JF_W(JF_W)) u_tgt (
    .pc        (pc_o),
    .kind      (kind),
    .offset    (offset),
    .jfield    (jfield),
    .rs_val    (rs_val_i),
    .rt_val    (rt_val_i),
    .pc_inc    (pc_inc),
    .next_pc   (next_pc),
    .redirect  (redirect),
    .link_req  (link_req),
    .bad_align (bad_align)
  );

  pcseq_state #(
    .XLEN(XLEN), .RIDX_W(RIDX_W), .RESET_PC(RESET_PC), .LINK_REG(LINK_REG)
  ) u_st (
    .clk         (clk),
    .rst         (rst),
    .next_pc     (next_pc),
    .ret_addr    (pc_inc),
    .redirect    (redirect),
    .link_req    (link_req),
    .bad_align   (bad_align),
    .pc_q        (pc_o),
    .taken_q     (taken_o),
    .link_we_q   (link_we_o),
    .link_idx_q  (link_idx_o),
    .link_data_q (link_data_o),
    .misalign_q  (misalign_o)
  );

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !taken_o) |-> (pc_o == $past(pc_o) + STEP_V));

  assert_beq_taken_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr_i[31:26]) == OPC_BEQ &&
     $past(rs_val_i) == $past(rt_val_i)) |-> taken_o);

  assert_bne_taken_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr_i[31:26]) == OPC_BNE &&
     $past(rs_val_i) != $past(rt_val_i)) |-> taken_o);

  assert_jreg_dest_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr_i[31:26]) == OPC_SPECIAL &&
     $past(instr_i[5:0]) == FN_JREG) |-> (taken_o && pc_o == $past(rs_val_i)));

  assert_link_data_R7: assert property (@(posedge clk) disable iff (rst)
    link_we_o |-> (link_data_o == $past(pc_o) + STEP_V));

endmodule

// File: tb/sim_pc_sequencer.sv
`timescale 1ns/1ps
module sim_pc_sequencer;

  localparam logic [31:0] RST_PC = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic [31:0] rsv = '0;
  logic [31:0] rtv = '0;
  logic [31:0] pc;
  logic        taken;
  logic        lwe;
  logic [4:0]  lidx;
  logic [31:0] ldata;
  logic        mis;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;
  logic [31:0] model_pc;

  always #2 clk = ~clk;

  pc_sequencer u0 (
    .clk(clk), .rst(rst), .instr_i(instr), .rs_val_i(rsv), .rt_val_i(rtv),
    .pc_o(pc), .taken_o(taken), .link_we_o(lwe), .link_idx_o(lidx),
    .link_data_o(ldata), .misalign_o(mis)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_br(input logic [5:0] op, input logic [15:0] off);
    return {op, 5'd3, 5'd4, off};
  endfunction

  function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] f);
    return {op, f};
  endfunction

  function automatic logic [31:0] enc_jr();
    return {6'd0, 5'd9, 15'd0, 6'h08};
  endfunction

  task automatic step(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                      input string tag);
    logic [31:0] inc, exp_pc, exp_ld;
    logic        exp_t, exp_l, exp_m;
    logic [5:0]  op;
    inc    = model_pc + 32'd4;
    op     = ins[31:26];
    exp_pc = inc;
    exp_t  = 1'b0;
    exp_l  = 1'b0;
    exp_m  = 1'b0;
    exp_ld = '0;
    if ((op == 6'h04 && a == b) || (op == 6'h05 && a != b)) begin
      exp_pc = inc + 32'($signed(ins[15:0]) * 4);
      exp_t  = 1'b1;
    end else if (op == 6'h02 || op == 6'h03) begin
      exp_pc = (inc & 32'hF000_0000) | (32'(ins[25:0]) * 32'd4);
      exp_t  = 1'b1;
      if (op == 6'h03) begin
        exp_l  = 1'b1;
        exp_ld = inc;
      end
    end else if (op == 6'h00 && ins[5:0] == 6'h08) begin
      exp_pc = a;
      exp_t  = 1'b1;
      exp_m  = (a[1:0] != 2'b00);
    end
    instr = ins;
    rsv   = a;
    rtv   = b;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " pc"}, pc, exp_pc);
    chk("R10 taken", 32'(taken), 32'(exp_t));
    chk("R7 link_we", 32'(lwe), 32'(exp_l));
    chk("R7 link_idx", 32'(lidx), exp_l ? 32'd31 : 32'd0);
    if (exp_l) chk("R7 link_data", ldata, exp_ld);
    chk("R9 misalign", 32'(mis), 32'(exp_m));
    model_pc = exp_pc;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pc", pc, RST_PC);
    chk("R1 reset taken", 32'(taken), 32'd0);
    chk("R1 reset link_we", 32'(lwe), 32'd0);
    chk("R1 reset misalign", 32'(mis), 32'd0);
    chk("R1 reset link_data", ldata, 32'd0);
    rst      = 1'b0;
    model_pc = RST_PC;

    step(32'h0000_0000, 32'd1, 32'd2, "R2 nop");
    step(32'h8C88_0004, 32'd5, 32'd5, "R2 load word");
    step({6'd0, 5'd1, 5'd2, 5'd3, 5'd0, 6'h20}, 32'd0, 32'd0, "R2 add funct");
    step({6'd0, 5'd1, 5'd2, 5'd3, 5'd0, 6'h09}, 32'h40, 32'd0, "R2 funct 09");

    for (int i = 0; i < 16; i++) begin
      logic [15:0] off;
      off = 16'(i * 16'h1111 + i);
      step(enc_br(6'h04, off), 32'(i), 32'(i), "R3 beq equal");
      step(enc_br(6'h04, off), 32'(i), 32'(i + 7), "R3 beq differ");
      step(enc_br(6'h05, off), 32'(i), 32'(i), "R4 bne equal");
      step(enc_br(6'h05, off), 32'hFFFF_0000, 32'(i), "R4 bne differ");
    end

    step(enc_jr(), RST_PC, 32'd0, "R8 jr home");
    step(enc_br(6'h04, 16'h7FFF), 32'd9, 32'd9, "R5 max positive");
    step(enc_br(6'h05, 16'h8000), 32'd1, 32'd0, "R5 max negative");
    step(enc_br(6'h04, 16'hFFFF), 32'd0, 32'd0, "R5 minus one word");
    step(enc_jr(), 32'h0000_0004, 32'd0, "R8 jr low");
    step(enc_br(6'h04, 16'hFFF0), 32'd2, 32'd2, "R5 wrap below zero");

    step(enc_jr(), 32'h0FFF_FFFC, 32'd0, "R8 jr to edge");
    step(enc_j(6'h02, 26'h000_0010), 32'd0, 32'd0, "R6 j upper from pc+4");
    for (int k = 0; k < 8; k++) begin
      step(enc_j(6'h02, 26'(k * 26'h0A5_A5A5 + 3)), 32'd0, 32'd0, "R6 j sweep");
      step(32'h0000_0000, 32'd0, 32'd0, "R10 after j");
    end

    step(enc_jr(), 32'h2FFF_FFFC, 32'd0, "R8 jr to edge2");
    step(enc_j(6'h03, 26'h3FF_FFFF), 32'd0, 32'd0, "R7 jal edge");
    for (int k = 0; k < 4; k++) begin
      step(enc_j(6'h03, 26'(k * 26'h111_1111)), 32'd0, 32'd0, "R7 jal sweep");
    end
    step(32'h0000_0000, 32'd0, 32'd0, "R7 after jal");

    step(enc_jr(), 32'h0040_0002, 32'd0, "R9 jr misaligned");
    step(32'h0000_0000, 32'd0, 32'd0, "R9 step after");
    step(enc_jr(), 32'h0040_0103, 32'd0, "R9 jr misaligned 3");
    step(enc_jr(), 32'h0040_0200, 32'd0, "R9 jr aligned");
    step(enc_j(6'h02, 26'd5), 32'd0, 32'd0, "R10 j back to back");
    step(enc_j(6'h02, 26'd9), 32'd0, 32'd0, "R10 j back to back");

    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 re-reset pc", pc, RST_PC);
    chk("R1 re-reset taken", 32'(taken), 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule